// File: doc/BRIEF.md
# Precise interrupt commit unit

This block decides, once per cycle, the fate of the instruction leaving the execute stage of a four-stage in-order pipeline (fetch, decode, execute, writeback). It sits between execute and writeback, and nothing upstream of it writes architectural state. The block owns the architectural program counter. This counter names the single address that may commit next. Fetch runs ahead on its own speculative counter. Every instruction brings along the address it was fetched from. An instruction whose address does not equal the architectural counter came from a wrongly predicted path. It is dropped, and fetch is sent back to the architectural counter. No separate branch-squash signal is needed.

An on-path instruction commits unless it carries an exception or an enabled external interrupt is pending. An exception may come from fetch, decode or execute. In either of those cases the instruction does not commit. The block flushes fetch, decode and execute, and steers fetch to a fixed handler address. It records a return address and a cause code, and it masks further interrupts. A return-from-handler instruction restores the saved address and unmasks interrupts. Sequential code is 4 bytes per instruction. The next address of each instruction is computed upstream and handed in.

Top module: `commit_unit`

## Requirements
- R1: After reset, arch_pc equals RESET_PC (default 0), epc and cause are 0, and irq_enable is 1.
- R2: A valid instruction whose ex_pc equals arch_pc, with ex_fault and ex_trap low and no accepted interrupt, commits. In that cycle wb_commit is 1 and pipe_flush is 0, and on the next edge arch_pc takes ex_next_pc.
- R3: A valid instruction whose ex_pc differs from arch_pc is discarded. wb_commit is 0, pipe_flush is 1 and fetch_redirect_pc equals arch_pc. arch_pc, epc, cause and irq_enable stay unchanged.
- R4: An on-path instruction with ex_fault high does not commit. pipe_flush is 1 and fetch_redirect_pc is HANDLER_PC (default 0x100). On the next edge arch_pc becomes HANDLER_PC, epc becomes ex_pc, cause becomes ex_cause and irq_enable becomes 0.
- R5: An on-path instruction with ex_trap high and ex_fault low behaves as in R4, except that epc becomes ex_next_pc. When both flags are high, the fault rule (R4) applies.
- R6: With irq_enable at 1, irq_req high and an on-path instruction carrying neither flag, that instruction does not commit. The flush and redirect to HANDLER_PC follow, epc becomes its ex_pc, cause becomes IRQ_CAUSE (default 4'hF) and irq_enable becomes 0.
- R7: When an on-path instruction carries ex_fault or ex_trap while an enabled interrupt is pending, the exception is taken. cause then equals ex_cause, not IRQ_CAUSE.
- R8: With irq_enable at 0, irq_req has no effect, and an on-path instruction commits as in R2.
- R9: An interrupt is taken only when a valid on-path instruction is at the commit point. While ex_valid is 0, a pending irq_req changes nothing. It is taken by the next on-path instruction.
- R10: An on-path instruction with ex_eret high, no exception and no accepted interrupt commits. It raises pipe_flush with fetch_redirect_pc equal to epc. On the next edge arch_pc becomes epc and irq_enable becomes 1.
- R11: While ex_valid is 0, wb_commit and pipe_flush are 0 and no state register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_valid | input | 1 | An instruction leaves execute this cycle |
| ex_pc | input | 32 | Address the instruction was fetched from |
| ex_next_pc | input | 32 | Sequential or branch-target successor address |
| ex_fault | input | 1 | Exception raised in fetch, decode or execute; return to ex_pc |
| ex_trap | input | 1 | Software trap; return to ex_next_pc |
| ex_cause | input | 4 | Cause code travelling with ex_fault or ex_trap |
| ex_eret | input | 1 | Instruction is a return from handler |
| irq_req | input | 1 | External interrupt request, level |
| wb_commit | output | 1 | Writeback may update state for this instruction |
| pipe_flush | output | 1 | Squash fetch, decode and execute; redirect fetch |
| fetch_redirect_pc | output | 32 | New speculative fetch address, meaningful with pipe_flush |
| arch_pc | output | 32 | Architectural program counter |
| epc | output | 32 | Saved return address |
| cause | output | 4 | Saved cause code |
| irq_enable | output | 1 | External interrupts accepted when 1 |

## Verification
Two functions can land in the same cycle. One is an exception carried by the instruction at the commit point. The other is an external request that is enabled at that moment. The bench sweeps every mix of valid, on-path, fault, trap, return and interrupt request from a bench model of the counters. Runs where an exception and the request coincide are judged on the saved cause and return address: the carried code must win, and the faulting or next address must be saved. A request raised while the slot is empty, and one raised while interrupts are masked, are both checked to see that nothing changes until an on-path instruction is at hand.

// File: rtl/commit_pkg.sv
package commit_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned CAUSE_W = 4;

  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [CAUSE_W-1:0] cause_t;

  // Outcome of the instruction at the commit point.
  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_RETIRE,
    ACT_DISCARD,
    ACT_FAULT,
    ACT_TRAP,
    ACT_IRQ,
    ACT_ERET
  } action_e;

  // True when a valid instruction lies on the architectural path.
  function automatic logic on_path(logic vld, addr_t pc, addr_t arch);
    return vld && (pc == arch);
  endfunction

  // A trap resumes after itself, a fault or interrupt re-runs the instruction.
  function automatic addr_t return_addr(addr_t pc, addr_t nxt, logic resume_after);
    return resume_after ? nxt : pc;
  endfunction

  function automatic logic enters_handler(action_e a);
    return (a == ACT_FAULT) || (a == ACT_TRAP) || (a == ACT_IRQ);
  endfunction
endpackage

// File: rtl/commit_decide.sv
module commit_decide
  import commit_pkg::*;
#(
  parameter addr_t  HANDLER_PC = 32'h0000_0100,
  parameter cause_t IRQ_CAUSE  = 4'hF
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    vld,
  input  addr_t   pc,
  input  addr_t   next_pc,
  input  logic    fault,
  input  logic    trap,
  input  cause_t  cause_in,
  input  logic    eret,
  input  logic    irq,
  input  logic    irq_en,
  input  addr_t   arch_pc,
  input  addr_t   epc,
  output action_e action,
  output logic    commit,
  output logic    flush,
  output addr_t   redirect_pc,
  output addr_t   epc_new,
  output cause_t  cause_new
);
  logic here;
  logic irq_taken;

  assign here      = on_path(vld, pc, arch_pc);
  assign irq_taken = irq && irq_en;

  always_comb begin
    action = ACT_IDLE;
    if (vld) begin
      if (!here)          action = ACT_DISCARD;
      else if (fault)     action = ACT_FAULT;
      else if (trap)      action = ACT_TRAP;
      else if (irq_taken) action = ACT_IRQ;
      else if (eret)      action = ACT_ERET;
      else                action = ACT_RETIRE;
    end
  end

  always_comb begin
    commit = (action == ACT_RETIRE) || (action == ACT_ERET);
    flush  = (action != ACT_IDLE) && (action != ACT_RETIRE);
    case (action)
      ACT_DISCARD: redirect_pc = arch_pc;
      ACT_ERET:    redirect_pc = epc;
      default:     redirect_pc = HANDLER_PC;
    endcase
    epc_new   = return_addr(pc, next_pc, action == ACT_TRAP);
    cause_new = (action == ACT_IRQ) ? IRQ_CAUSE : cause_in;
  end

  // R7: a carried exception never yields to an external request
  a_r7_exc_beats_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (here && (fault || trap)) |-> (action != ACT_IRQ));

  // R8: a masked request never enters the handler
  a_r8_masked_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> (action != ACT_IRQ));

  // R2, R3: commit and flush never together except on a return
  a_r2_commit_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && flush) |-> (action == ACT_ERET));

  // R11: an empty slot produces no control pulse
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |-> (!commit && !flush));
endmodule

// File: rtl/commit_state.sv
module commit_state
  import commit_pkg::*;
#(
  parameter addr_t RESET_PC   = 32'h0000_0000,
  parameter addr_t HANDLER_PC = 32'h0000_0100
) (
  input  logic    clk,
  input  logic    rst_n,
  input  action_e action,
  input  addr_t   next_pc,
  input  addr_t   epc_new,
  input  cause_t  cause_new,
  output addr_t   arch_pc,
  output addr_t   epc,
  output cause_t  cause,
  output logic    irq_en
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arch_pc <= RESET_PC;
      epc     <= '0;
      cause   <= '0;
      irq_en  <= 1'b1;
    end else begin
      case (action)
        ACT_RETIRE: arch_pc <= next_pc;
        ACT_FAULT, ACT_TRAP, ACT_IRQ: begin
          arch_pc <= HANDLER_PC;
          epc     <= epc_new;
          cause   <= cause_new;
          irq_en  <= 1'b0;
        end
        ACT_ERET: begin
          arch_pc <= epc;
          irq_en  <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R2: a retired instruction hands its successor address to the counter
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (action == ACT_RETIRE) |=> (arch_pc == $past(next_pc)));

  // R3: a wrong-path instruction leaves every state register alone
  a_r3_discard_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (action == ACT_DISCARD) |=> ($stable(arch_pc) && $stable(epc) && $stable(cause) && $stable(irq_en)));

  // R4: handler entry vectors and masks
  a_r4_handler_entry: assert property (@(posedge clk) disable iff (!rst_n)
    enters_handler(action) |=> ((arch_pc == HANDLER_PC) && !irq_en));

  // R10: return restores the saved address and unmasks
  a_r10_return: assert property (@(posedge clk) disable iff (!rst_n)
    (action == ACT_ERET) |=> ((arch_pc == $past(epc)) && irq_en));

  // R11: idle cycles hold state
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (action == ACT_IDLE) |=> ($stable(arch_pc) && $stable(epc) && $stable(irq_en)));
endmodule

// File: rtl/commit_unit.sv
module commit_unit
  import commit_pkg::*;
#(
  parameter addr_t  RESET_PC   = 32'h0000_0000,
  parameter addr_t  HANDLER_PC = 32'h0000_0100,
  parameter cause_t IRQ_CAUSE  = 4'hF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ex_valid,
  input  logic [ADDR_W-1:0]  ex_pc,
  input  logic [ADDR_W-1:0]  ex_next_pc,
  input  logic               ex_fault,
  input  logic               ex_trap,
  input  logic [CAUSE_W-1:0] ex_cause,
  input  logic               ex_eret,
  input  logic               irq_req,
  output logic               wb_commit,
  output logic               pipe_flush,
  output logic [ADDR_W-1:0]  fetch_redirect_pc,
  output logic [ADDR_W-1:0]  arch_pc,
  output logic [ADDR_W-1:0]  epc,
  output logic [CAUSE_W-1:0] cause,
  output logic               irq_enable
);
  action_e act;
  addr_t   epc_next;
  cause_t  cause_next;

  commit_decide #(
    .HANDLER_PC (HANDLER_PC),
    .IRQ_CAUSE  (IRQ_CAUSE)
  ) u_decide (
    .clk         (clk),
    .rst_n       (rst_n),
    .vld         (ex_valid),
    .pc          (ex_pc),
    .next_pc     (ex_next_pc),
    .fault       (ex_fault),
    .trap        (ex_trap),
    .cause_in    (ex_cause),
    .eret        (ex_eret),
    .irq         (irq_req),
    .irq_en      (irq_enable),
    .arch_pc     (arch_pc),
    .epc         (epc),
    .action      (act),
    .commit      (wb_commit),
    .flush       (pipe_flush),
    .redirect_pc (fetch_redirect_pc),
    .epc_new     (epc_next),
    .cause_new   (cause_next)
  );

  commit_state #(
    .RESET_PC   (RESET_PC),
    .HANDLER_PC (HANDLER_PC)
  ) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .action    (act),
    .next_pc   (ex_next_pc),
    .epc_new   (epc_next),
    .cause_new (cause_next),
    .arch_pc   (arch_pc),
    .epc       (epc),
    .cause     (cause),
    .irq_en    (irq_enable)
  );

  // R6: an interrupt taken at an on-path slot blocks that slot's commit
  a_r6_irq_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_enable && ex_valid && (ex_pc == arch_pc) && !ex_fault && !ex_trap)
      |-> (!wb_commit && pipe_flush && (fetch_redirect_pc == HANDLER_PC)));
endmodule

// File: tb/commit_unit_test.sv
`timescale 1ns/1ps
module commit_unit_test;
  localparam logic [31:0] HANDLER = 32'h0000_0100;
  localparam logic [3:0]  IRQC    = 4'hF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ex_valid = 1'b0;
  logic [31:0] ex_pc = '0;
  logic [31:0] ex_next_pc = '0;
  logic        ex_fault = 1'b0;
  logic        ex_trap = 1'b0;
  logic [3:0]  ex_cause = '0;
  logic        ex_eret = 1'b0;
  logic        irq_req = 1'b0;
  logic        wb_commit, pipe_flush, irq_enable;
  logic [31:0] fetch_redirect_pc, arch_pc, epc;
  logic [3:0]  cause;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_pc, m_epc;
  logic [3:0]  m_cause;
  logic        m_ien;

  always #10 clk = ~clk;

  commit_unit uut (
    .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_pc(ex_pc),
    .ex_next_pc(ex_next_pc), .ex_fault(ex_fault), .ex_trap(ex_trap),
    .ex_cause(ex_cause), .ex_eret(ex_eret), .irq_req(irq_req),
    .wb_commit(wb_commit), .pipe_flush(pipe_flush),
    .fetch_redirect_pc(fetch_redirect_pc), .arch_pc(arch_pc), .epc(epc),
    .cause(cause), .irq_enable(irq_enable)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] pc, input logic [31:0] nxt,
                      input logic f, input logic t, input logic [3:0] c,
                      input logic e, input logic i, input string tag);
    logic on, flt, trp, itk, er, ret, dis, fl;
    logic [31:0] rd;
    @(negedge clk);
    ex_valid = v; ex_pc = pc; ex_next_pc = nxt; ex_fault = f; ex_trap = t;
    ex_cause = c; ex_eret = e; irq_req = i;
    on  = v && (pc == m_pc);
    dis = v && !on;
    flt = on && f;
    trp = on && !f && t;
    itk = on && !f && !t && i && m_ien;
    er  = on && !f && !t && !itk && e;
    ret = on && !f && !t && !itk;
    fl  = dis || flt || trp || itk || er;
    rd  = dis ? m_pc : (er ? m_epc : HANDLER);
    #5;
    chk(tag, "commit", {31'b0, wb_commit}, {31'b0, ret});
    chk(tag, "flush", {31'b0, pipe_flush}, {31'b0, fl});
    if (fl) chk(tag, "redirect", fetch_redirect_pc, rd);
    if (flt || trp || itk) begin
      m_epc   = trp ? nxt : pc;
      m_cause = itk ? IRQC : c;
      m_ien   = 1'b0;
      m_pc    = HANDLER;
    end else if (er) begin
      m_pc  = m_epc;
      m_ien = 1'b1;
    end else if (ret) begin
      m_pc = nxt;
    end
    @(posedge clk);
    #1;
    chk(tag, "arch_pc", arch_pc, m_pc);
    chk(tag, "epc", epc, m_epc);
    chk(tag, "cause", {28'b0, cause}, {28'b0, m_cause});
    chk(tag, "irq_enable", {31'b0, irq_enable}, {31'b0, m_ien});
  endtask

  function automatic string sweep_tag(logic v, logic m, logic f, logic t,
                                      logic e, logic i, logic ien);
    if (!v) return "R11";
    if (!m) return "R3";
    if ((f || t) && i && ien) return "R7";
    if (f) return "R4";
    if (t) return "R5";
    if (i && ien) return "R6";
    if (i) return "R8";
    if (e) return "R10";
    return "R2";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_pc = 32'h0; m_epc = 32'h0; m_cause = 4'h0; m_ien = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1: reset values
    chk("R1", "arch_pc", arch_pc, 32'h0);
    chk("R1", "epc", epc, 32'h0);
    chk("R1", "cause", {28'b0, cause}, 32'h0);
    chk("R1", "irq_enable", {31'b0, irq_enable}, 32'h1);

    // R2 then R3: jump at 0x00 to 0x1234, wrong-path 0x04 dropped
    step(1, 32'h0, 32'h1234, 0, 0, 4'h0, 0, 0, "R2");
    step(1, 32'h4, 32'h8,    0, 0, 4'h0, 0, 0, "R3");
    step(1, 32'h1234, 32'h1238, 0, 0, 4'h0, 0, 0, "R2");

    // R9: request held while slot empty, taken by next on-path instruction
    step(0, 32'h0, 32'h0, 0, 0, 4'h0, 0, 1, "R9");
    step(0, 32'h0, 32'h0, 0, 0, 4'h0, 0, 1, "R9");
    step(1, 32'h1238, 32'h123C, 0, 0, 4'h0, 0, 1, "R9");
    // R8: masked inside handler
    step(1, HANDLER, HANDLER + 4, 0, 0, 4'h0, 0, 1, "R8");
    // R10: return to 0x1238
    step(1, HANDLER + 4, HANDLER + 8, 0, 0, 4'h0, 1, 0, "R10");
    // R7: fault with enabled interrupt
    step(1, 32'h1238, 32'h123C, 1, 0, 4'h3, 0, 1, "R7");
    step(1, HANDLER, HANDLER + 4, 0, 0, 4'h0, 1, 0, "R10");
    // R5: trap saves next address
    step(1, 32'h1238, 32'h123C, 0, 1, 4'h8, 0, 0, "R5");
    step(1, HANDLER, HANDLER + 4, 0, 0, 4'h0, 1, 0, "R10");
    step(1, 32'h123C, 32'h1240, 0, 0, 4'h0, 0, 0, "R2");

    // near-exhaustive sweep over the six control inputs, two passes
    for (int pass = 0; pass < 2; pass++) begin
      for (int k = 0; k < 64; k++) begin
        logic v, m, f, t, e, i;
        logic [31:0] pc;
        v = k[0]; m = k[1]; f = k[2]; t = k[3]; e = k[4]; i = k[5];
        if (pass == 1) i = ~i;
        pc = m ? m_pc : (m_pc ^ 32'h40);
        step(v, pc, pc + 32'd4 * (k + 1), f, t, k[3:0] ^ 4'h5, e, i,
             sweep_tag(v, m, f, t, e, i, m_ien));
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule